// File: doc/BRIEF.md
# Memory security attribution checker

This block decides, for every processor access, which security attribute the target address carries. It also decides whether the access may go out on the bus and, if so, with which bus security bit. Two sources feed the decision. The first is a hardwired region map: the address space is cut into equal windows, and each physical block appears twice, once in a Non-secure window and once in a Secure window. The second is a software-programmable table of address ranges with its own control register. Whichever of the two sources reports the more secure attribute wins.

A Secure window of the hardwired map can be switched to Non-secure-callable, one window pair per bit of a small configuration register. The programmable side has three states. Disabled, it reports everything as Secure. Disabled with the all-non-secure bit set, it reports everything as Non-secure, so the hardwired map alone decides. Enabled, it looks the address up in its range table. The access path is purely combinational. Configuration arrives through a one-word register write port and takes effect on the clock edge that samples the write.

Top module: `sec_attr_unit`

## Requirements
- R1: `eff_attr` encodes Non-secure as 2'b00, Non-secure-callable as 2'b01 and Secure as 2'b10, and it is always the stronger (numerically larger) of the hardwired-map attribute and the programmable-table attribute.
- R2: The hardwired map takes the top `MAP_BITS` address bits as the window index. An even index is Non-secure and an odd index is Secure, so windows 2k and 2k+1 alias the same block.
- R3: Configuration word 1 holds the callable selects. When bit k is 1, odd window 2k+1 reports Non-secure-callable instead of Secure. No other window is affected.
- R4: After reset, the control word, the callable selects and every table entry are zero, and every address is effectively Secure.
- R5: When control bit 0 (enable) is 0 and control bit 1 (all-non-secure) is 1, the effective attribute equals the hardwired-map attribute. With both bits 0, every address is Secure.
- R6: With enable set, entry i is written at word 2+2i (base, bits [ADDR_W-1:5]) and word 3+2i (inclusive limit in bits [ADDR_W-1:5], NSC flag in bit 1, entry enable in bit 0). An address whose bits [ADDR_W-1:5] fall within exactly one enabled entry reports Non-secure, or Non-secure-callable if that entry's NSC flag is set. Address bits [4:0] play no part in the lookup.
- R7: With enable set, an address that matches no enabled entry is Secure.
- R8: With enable set, an address that matches two or more enabled entries is Secure.
- R9: `fault` is 1 for any access made in Non-secure state to a Secure or Non-secure-callable address, and for an instruction fetch made in Secure state from a Non-secure address. It is 0 otherwise.
- R10: `bus_nonsec` is 1 exactly when the effective attribute is Non-secure. A Secure-state data access to a Non-secure address therefore leaves with `bus_nonsec` = 1 and no fault.
- R11: Outputs follow the access inputs in the same cycle. A configuration write changes the outputs only after the rising edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (5) | Configuration word index |
| cfg_wdata | input | ADDR_W (32) | Configuration write data |
| acc_addr | input | ADDR_W (32) | Access address |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| cpu_secure | input | 1 | 1 = processor is in Secure state |
| eff_attr | output | 2 | Effective attribute (R1 encoding) |
| bus_nonsec | output | 1 | Bus security bit, 1 = Non-secure |
| fault | output | 1 | Access blocked, raise a fault |

## Verification
The bench builds the block with a 12-bit address, four table entries, a 4-bit window index and two callable selects. This gives 128 distinct 32-byte granules. Every granule can then be swept with each combination of access kind and processor state under each configuration. Overlapping entries, entries that are present but not enabled, inclusive limit edges and both callable selects all fit inside that small space, and the expected attribute is recomputed from a shadow of the written configuration.

// File: rtl/sau_pkg.sv
`timescale 1ns/1ps
package sau_pkg;
  // Attribute ordering is by strength: a larger code is more secure.
  typedef enum logic [1:0] {
    ATTR_NS  = 2'b00,
    ATTR_NSC = 2'b01,
    ATTR_S   = 2'b10
  } attr_e;

  // Table granule: 32-byte aligned bases and limits.
  localparam int GRAN_BITS = 5;

  function automatic attr_e attr_max(attr_e a, attr_e b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fixed_attr_map.sv
`timescale 1ns/1ps
module fixed_attr_map
  import sau_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int MAP_BITS = 4,
  parameter int NSC_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                nsc_we,
  input  logic [NSC_W-1:0]    nsc_wdata,
  input  logic [MAP_BITS-1:0] win_idx,
  output attr_e               attr
);
  localparam int PAIR_W = MAP_BITS - 1;

  logic [NSC_W-1:0]  nsc_q;
  logic [NSC_W-1:0]  sel_nsc;
  logic [PAIR_W-1:0] pair;

  always_ff @(posedge clk) begin
    if (rst)         nsc_q <= '0;
    else if (nsc_we) nsc_q <= nsc_wdata;
  end

  assign pair = win_idx[MAP_BITS-1:1];

  for (genvar k = 0; k < NSC_W; k++) begin : g_sel
    assign sel_nsc[k] = nsc_q[k] && (pair == PAIR_W'(k));
  end

  always_comb begin
    if (!win_idx[0])   attr = ATTR_NS;
    else if (|sel_nsc) attr = ATTR_NSC;
    else               attr = ATTR_S;
  end
endmodule

// File: rtl/prog_attr_table.sv
`timescale 1ns/1ps
module prog_attr_table
  import sau_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_REG  = 8,
  localparam int TAG_W = ADDR_W - GRAN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [1:0]        ctrl_wdata,
  input  logic [N_REG-1:0]  base_we,
  input  logic [N_REG-1:0]  lim_we,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [1:0]        wr_flags,
  input  logic [TAG_W-1:0]  acc_tag,
  output attr_e             attr,
  output logic              ctrl_en,
  output logic              ctrl_allns
);
  logic [TAG_W-1:0] base_q [N_REG];
  logic [TAG_W-1:0] lim_q  [N_REG];
  logic [N_REG-1:0] ren_q;
  logic [N_REG-1:0] rnsc_q;
  logic [N_REG-1:0] hit;
  logic             one_hit;
  logic             hit_nsc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_allns <= 1'b0;
    end else if (ctrl_we) begin
      ctrl_en    <= ctrl_wdata[0];
      ctrl_allns <= ctrl_wdata[1];
    end
  end

  for (genvar i = 0; i < N_REG; i++) begin : g_rgn
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
        ren_q[i]  <= 1'b0;
        rnsc_q[i] <= 1'b0;
      end else begin
        if (base_we[i]) base_q[i] <= wr_tag;
        if (lim_we[i]) begin
          lim_q[i]  <= wr_tag;
          ren_q[i]  <= wr_flags[0];
          rnsc_q[i] <= wr_flags[1];
        end
      end
    end
    assign hit[i] = ren_q[i] && (acc_tag >= base_q[i]) && (acc_tag <= lim_q[i]);
  end

  assign one_hit = (|hit) && ((hit & (hit - 1'b1)) == '0);
  assign hit_nsc = |(hit & rnsc_q);

  always_comb begin
    if (!ctrl_en)     attr = ctrl_allns ? ATTR_NS : ATTR_S;
    else if (one_hit) attr = hit_nsc ? ATTR_NSC : ATTR_NS;
    else              attr = ATTR_S;
  end
endmodule

// File: rtl/access_judge.sv
`timescale 1ns/1ps
module access_judge
  import sau_pkg::*;
(
  input  attr_e fix_attr,
  input  attr_e prog_attr,
  input  logic  acc_fetch,
  input  logic  cpu_secure,
  output attr_e eff,
  output logic  bus_nonsec,
  output logic  fault
);
  assign eff        = attr_max(fix_attr, prog_attr);
  assign bus_nonsec = (eff == ATTR_NS);
  assign fault      = cpu_secure ? (acc_fetch && eff == ATTR_NS) : (eff != ATTR_NS);
endmodule

// File: rtl/sec_attr_unit.sv
`timescale 1ns/1ps
module sec_attr_unit
  import sau_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int N_REG    = 8,
  parameter int MAP_BITS = 4,
  parameter int NSC_W    = 2,
  localparam int CFG_AW  = $clog2(2 + 2 * N_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_fetch,
  input  logic              cpu_secure,
  output logic [1:0]        eff_attr,
  output logic              bus_nonsec,
  output logic              fault
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic             ctrl_we;
  logic             nsc_we;
  logic [N_REG-1:0] base_we;
  logic [N_REG-1:0] lim_we;
  attr_e            fix_attr;
  attr_e            prog_attr;
  attr_e            eff;
  logic             ctrl_en;
  logic             ctrl_allns;
  logic             unused_bits;

  assign ctrl_we = cfg_we && (cfg_addr == CFG_AW'(0));
  assign nsc_we  = cfg_we && (cfg_addr == CFG_AW'(1));

  for (genvar i = 0; i < N_REG; i++) begin : g_dec
    assign base_we[i] = cfg_we && (cfg_addr == CFG_AW'(2 + 2 * i));
    assign lim_we[i]  = cfg_we && (cfg_addr == CFG_AW'(3 + 2 * i));
  end

  assign unused_bits = ^{cfg_wdata[GRAN_BITS-1:2], acc_addr[GRAN_BITS-1:0]};

  fixed_attr_map #(
    .ADDR_W(ADDR_W), .MAP_BITS(MAP_BITS), .NSC_W(NSC_W)
  ) u_fix (
    .clk(clk), .rst(rst),
    .nsc_we(nsc_we), .nsc_wdata(cfg_wdata[NSC_W-1:0]),
    .win_idx(acc_addr[ADDR_W-1 -: MAP_BITS]),
    .attr(fix_attr)
  );

  prog_attr_table #(
    .ADDR_W(ADDR_W), .N_REG(N_REG)
  ) u_tbl (
    .clk(clk), .rst(rst),
    .ctrl_we(ctrl_we), .ctrl_wdata(cfg_wdata[1:0]),
    .base_we(base_we), .lim_we(lim_we),
    .wr_tag(cfg_wdata[ADDR_W-1:GRAN_BITS]), .wr_flags(cfg_wdata[1:0]),
    .acc_tag(acc_addr[ADDR_W-1:GRAN_BITS]),
    .attr(prog_attr), .ctrl_en(ctrl_en), .ctrl_allns(ctrl_allns)
  );

  access_judge u_judge (
    .fix_attr(fix_attr), .prog_attr(prog_attr),
    .acc_fetch(acc_fetch), .cpu_secure(cpu_secure),
    .eff(eff), .bus_nonsec(bus_nonsec), .fault(fault)
  );

  assign eff_attr = eff;
endmodule

// File: rtl/sec_attr_checker.sv
`timescale 1ns/1ps
module sec_attr_checker #(
  parameter int CFG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_we,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [1:0]        ctrl_wdata,
  input logic              acc_fetch,
  input logic              cpu_secure,
  input logic [1:0]        eff_attr,
  input logic              bus_nonsec,
  input logic              fault,
  input logic [1:0]        fix_attr,
  input logic [1:0]        prog_attr,
  input logic              ctrl_en,
  input logic              ctrl_allns
);
  AST_EFF_NOT_BELOW_MAP: assert property (@(posedge clk) disable iff (rst)
    eff_attr >= fix_attr); // R1
  AST_EFF_NOT_BELOW_TABLE: assert property (@(posedge clk) disable iff (rst)
    eff_attr >= prog_attr); // R1
  AST_EFF_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    eff_attr != 2'b11); // R1
  AST_OFF_ALL_SECURE: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && !ctrl_allns) |-> eff_attr == 2'b10); // R4
  AST_ALLNS_GIVES_MAP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_en && ctrl_allns) |-> eff_attr == fix_attr); // R5
  AST_NS_STATE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (!cpu_secure && eff_attr != 2'b00) |-> fault); // R9
  AST_SEC_DATA_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (cpu_secure && !acc_fetch) |-> !fault); // R10
  AST_NS_ISSUE_NONSEC: assert property (@(posedge clk) disable iff (rst)
    (!cpu_secure && !fault) |-> bus_nonsec); // R10
  AST_CTRL_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == '0) |=>
      (ctrl_en == $past(ctrl_wdata[0]) && ctrl_allns == $past(ctrl_wdata[1]))); // R11
endmodule

bind sec_attr_unit sec_attr_checker #(.CFG_AW(CFG_AW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .ctrl_wdata(cfg_wdata[1:0]), .acc_fetch(acc_fetch), .cpu_secure(cpu_secure),
  .eff_attr(eff_attr), .bus_nonsec(bus_nonsec), .fault(fault),
  .fix_attr(fix_attr), .prog_attr(prog_attr),
  .ctrl_en(ctrl_en), .ctrl_allns(ctrl_allns)
);

// File: tb/test_sec_attr_unit.sv
`timescale 1ns/1ps
module test_sec_attr_unit;
  localparam int AW = 12;
  localparam int NR = 4;
  localparam int MB = 4;
  localparam int NW = 2;
  localparam int CA = $clog2(2 + 2 * NR);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [CA-1:0] cfg_addr = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] acc_addr = '0;
  logic          acc_fetch = 1'b0;
  logic          cpu_secure = 1'b1;
  logic [1:0]    eff_attr;
  logic          bus_nonsec;
  logic          fault;

  int checks = 0;
  int errors = 0;

  // Shadow of the written configuration
  logic          m_en = 0, m_allns = 0;
  logic [NW-1:0] m_nsc = '0;
  logic [6:0]    m_base [NR];
  logic [6:0]    m_lim  [NR];
  logic [NR-1:0] m_ren = '0, m_rnsc = '0;

  always #5 clk = ~clk;

  sec_attr_unit #(.ADDR_W(AW), .N_REG(NR), .MAP_BITS(MB), .NSC_W(NW)) i_sec_attr_unit (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .acc_addr(acc_addr), .acc_fetch(acc_fetch), .cpu_secure(cpu_secure),
    .eff_attr(eff_attr), .bus_nonsec(bus_nonsec), .fault(fault)
  );

  function automatic logic [1:0] m_fix(logic [AW-1:0] a);
    logic [3:0] idx = a[AW-1 -: MB];
    int k = int'(idx[3:1]);
    if (!idx[0]) return 2'b00;
    if (k < NW && m_nsc[k]) return 2'b01;
    return 2'b10;
  endfunction

  function automatic logic [1:0] m_prog(logic [AW-1:0] a);
    logic [6:0] t = a[AW-1:5];
    int hits = 0;
    int last = 0;
    if (!m_en) return m_allns ? 2'b00 : 2'b10;
    for (int i = 0; i < NR; i++)
      if (m_ren[i] && t >= m_base[i] && t <= m_lim[i]) begin
        hits++;
        last = i;
      end
    if (hits == 1) return m_rnsc[last] ? 2'b01 : 2'b00;
    return 2'b10;
  endfunction

  function automatic logic [1:0] m_eff(logic [AW-1:0] a);
    logic [1:0] f = m_fix(a);
    logic [1:0] p = m_prog(a);
    return (f > p) ? f : p;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [AW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = CA'(a); cfg_wdata = d;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    if (a == 0) begin m_en = d[0]; m_allns = d[1]; end
    else if (a == 1) m_nsc = d[NW-1:0];
    else if (a % 2 == 0) m_base[(a - 2) / 2] = d[AW-1:5];
    else begin
      m_lim[(a - 3) / 2]  = d[AW-1:5];
      m_ren[(a - 3) / 2]  = d[0];
      m_rnsc[(a - 3) / 2] = d[1];
    end
  endtask

  task automatic probe(logic [AW-1:0] a, logic s, logic f);
    @(negedge clk);
    acc_addr = a; cpu_secure = s; acc_fetch = f;
    #1;
  endtask

  task automatic one(string tag, logic [AW-1:0] a, logic [1:0] exp);
    probe(a, 1'b1, 1'b0);
    chk(tag, $sformatf("attr @%0h", a), eff_attr, exp);
  endtask

  task automatic sweep(string tag);
    for (int g = 0; g < 128; g++) begin
      for (int s = 0; s < 2; s++) begin
        for (int f = 0; f < 2; f++) begin
          logic [AW-1:0] a = AW'(g * 32 + (g % 32));
          logic [1:0] e = m_eff(a);
          logic ef = s[0] ? (f[0] && e == 2'b00) : (e != 2'b00);
          probe(a, s[0], f[0]);
          chk(tag, $sformatf("attr @%0h", a), eff_attr, e);
          chk("R9", $sformatf("fault @%0h s%0d f%0d", a, s, f), fault, ef);
          chk("R10", $sformatf("bus_nonsec @%0h", a), bus_nonsec, e == 2'b00);
        end
      end
    end
  endtask

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) begin m_base[i] = '0; m_lim[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R4: reset state, everything Secure
    sweep("R4");

    // R11: write lands only after the sampling edge
    probe(12'h000, 1'b1, 1'b0);
    cfg_we = 1'b1; cfg_addr = '0; cfg_wdata = 12'h002;
    #1 chk("R11", "attr before edge", eff_attr, 2);
    @(posedge clk);
    #1 cfg_we = 1'b0; m_allns = 1'b1;
    chk("R11", "attr after edge", eff_attr, 0);

    // R2 / R5: disabled with all-non-secure follows the hardwired map
    sweep("R5");
    wr(1, 12'h001);
    one("R3", 12'h120, 2'b01);
    one("R3", 12'h345, 2'b10);
    one("R2", 12'h220, 2'b00);
    one("R2", 12'hF00, 2'b10);
    sweep("R2");
    wr(1, 12'h002);
    one("R3", 12'h120, 2'b10);
    one("R3", 12'h345, 2'b01);
    sweep("R3");

    // R6-R8: table enabled
    wr(2, 12'h200); wr(3, 12'h2E1);          // entry0 0x200..0x2FF NS
    wr(4, 12'h400); wr(5, 12'h463);          // entry1 0x400..0x47F NSC
    wr(6, 12'h280); wr(7, 12'h281);          // entry2 0x280..0x29F overlap
    wr(8, 12'h600); wr(9, 12'h6E0);          // entry3 present, not enabled
    wr(0, 12'h001);
    one("R6", 12'h21F, 2'b00);
    one("R6", 12'h2FF, 2'b00);
    one("R6", 12'h300, 2'b10);
    one("R6", 12'h410, 2'b01);
    one("R6", 12'h650, 2'b10);
    one("R7", 12'h800, 2'b10);
    one("R8", 12'h290, 2'b10);
    one("R8", 12'h27F, 2'b00);
    probe(12'h230, 1'b1, 1'b0);
    chk("R10", "secure data to NS bus bit", bus_nonsec, 1);
    chk("R10", "secure data to NS fault", fault, 0);
    probe(12'h230, 1'b1, 1'b1);
    chk("R9", "secure fetch from NS", fault, 1);
    probe(12'h410, 1'b0, 1'b1);
    chk("R9", "NS fetch from NSC", fault, 1);
    sweep("R1");

    // R4 again: disabled, all-non-secure clear
    wr(0, 12'h000);
    sweep("R4");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule